// File: doc/BRIEF.md
# Per-Phase Apparent-Energy Accumulator with Half-Full Interrupt

This block holds one signed energy counter for each of three phases. An upstream threshold stage sends a pulse for each phase whenever a fixed quantum of apparent energy has built up. On a clock edge where the 8 kHz sample tick is high, each phase whose pulse input is high adds one to its counter. Apparent energy never goes negative, so the counters only count up. When a counter reaches the largest positive value, it holds there and does not wrap.

When any counter climbs past the halfway point of its positive range, a sticky status flag is set. An active-low interrupt line follows that flag through a mask register. Software can therefore drain the counters long before they would saturate. Software clears the flag by writing a one to it. A mode bit makes each counter reset when it is read, so every read returns only the energy gathered since the previous read. A pulse that lands on the same edge as such a read is kept in the counter and is not lost.

Software reads a counter with a one-cycle strobe and a phase select. It writes the status, mask and mode registers through a small write port.

Top module: `eacc_top`

## Requirements
- R1: After reset, all three counters, the status, mask and mode registers, and `rdData` are zero, `rdValid` is low and `irqN` is high.
- R2: On a clock edge with `sampleTick` high, each counter whose `pulseIn` bit is high increases by exactly one. When `sampleTick` is low, `pulseIn` has no effect.
- R3: A counter that holds the largest positive value (2^(ACC_W-1)-1, 0x7FFFFFFF at the default width) stays at that value when more pulses arrive. It never becomes negative.
- R4: A read strobe with `rdSel` of 0, 1 or 2 selects phase A, B or C. On the next cycle `rdData` holds the counter value from just before the strobe edge, and `rdValid` is high for that one cycle. `rdSel` = 3 returns zero and alters no counter.
- R5: Status bit 4 is set on the edge where an increment moves counter bit ACC_W-2 from 0 to 1 (0x3FFFFFFF to 0x40000000 at the default width). It then stays set until software clears it. Clearing a counter, or holding a counter at saturation, never sets it.
- R6: A write to address 0 clears each status bit whose `wrData` bit is 1. A 0 in `wrData` leaves the matching status bit unchanged. If a half-full event happens on the same edge as the clearing write, the bit stays set.
- R7: Address 1 is the mask register. `irqN` is low exactly when some status bit and its mask bit are both 1. With mask bit 4 clear, a set half-full flag leaves `irqN` high.
- R8: Address 2 is the mode register. When mode bit 6 is 1, a read of phase 0 to 2 returns the counter value and clears that counter on the same edge. When mode bit 6 is 0, reads leave the counters unchanged.
- R9: If a clearing read and a counted pulse for the same phase land on one edge, that counter becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | Sample-rate enable, high for one cycle per 125 µs |
| pulseIn | input | 3 | Energy pulse from the threshold stage, one bit per phase |
| rdStrobe | input | 1 | Counter read request |
| rdSel | input | 2 | Phase to read (0 = A, 1 = B, 2 = C) |
| rdData | output | ACC_W | Value of the counter that was read |
| rdValid | output | 1 | `rdData` updated this cycle |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | 0 = status, 1 = mask, 2 = mode |
| wrData | input | 8 | Write data |
| statusOut | output | 8 | Status register (bit 4 = half-full) |
| irqN | output | 1 | Interrupt, active low |

## Verification
A counter that picks up or drops a count shows up at `rdData` on the first read after the error. The bench reads after each group of pulses, so it finds such a fault within a few cycles. A flag that misses or mistimes the halfway crossing appears on `statusOut` on the same edge as the crossing increment. It then reaches `irqN` with no further delay once the mask is set. A wrong clear-on-read or coincidence rule is visible on the next read of the same phase, which returns a non-zero leftover value or loses the simultaneous pulse.

// File: rtl/eacc_pkg.sv
package eacc_pkg;
  localparam int NUM_PHASES   = 3;
  localparam int SEL_W        = 2;
  localparam int ADDR_W       = 2;
  localparam int REG_W        = 8;
  localparam int HALF_FLAG    = 4;
  localparam int RD_RESET_BIT = 6;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_MODE   = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic                  rdEn;
    logic [SEL_W-1:0]      rdSel;
    logic [NUM_PHASES-1:0] clrAcc;
  } dpStrobes_t;
endpackage

// File: rtl/eacc_datapath.sv
module eacc_datapath
  import eacc_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 sampleTick,
  input  logic [NUM_PHASES-1:0]                pulseIn,
  input  dpStrobes_t                           strobes,
  output logic [ACC_W-1:0]                     rdData,
  output logic                                 rdValid,
  output logic                                 halfEvt,
  output logic [NUM_PHASES-1:0][ACC_W-1:0]     accVal
);
  localparam int HALF_POS = ACC_W - 2;
  localparam logic [ACC_W-1:0] SAT_VAL = {1'b0, {(ACC_W-1){1'b1}}};

  logic [NUM_PHASES-1:0] hitVec;

  for (genvar g = 0; g < NUM_PHASES; g++) begin : gPhase
    logic [ACC_W-1:0] accReg;
    logic [ACC_W-1:0] incVal;
    logic [ACC_W-1:0] nextAcc;
    logic             counted;
    logic             bump;

    always_comb begin
      counted = sampleTick & pulseIn[g];
      bump    = counted & (accReg != SAT_VAL);
      incVal  = accReg + {{(ACC_W-1){1'b0}}, bump};
      if (strobes.clrAcc[g])
        nextAcc = {{(ACC_W-1){1'b0}}, counted};
      else
        nextAcc = incVal;
      hitVec[g] = bump & ~strobes.clrAcc[g] & ~accReg[HALF_POS] & incVal[HALF_POS];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) accReg <= '0;
      else       accReg <= nextAcc;
    end

    assign accVal[g] = accReg;
  end

  assign halfEvt = |hitVec;

  logic [ACC_W-1:0] selVal;
  always_comb begin
    selVal = '0;
    for (int p = 0; p < NUM_PHASES; p++)
      if (strobes.rdSel == SEL_W'(p)) selVal = accVal[p];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobes.rdEn;
      if (strobes.rdEn) rdData <= selVal;
    end
  end
endmodule

// File: rtl/eacc_ctrl.sv
module eacc_ctrl
  import eacc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStrobe,
  input  logic [SEL_W-1:0]  rdSel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              halfEvt,
  output dpStrobes_t        strobes,
  output logic [REG_W-1:0]  statusReg,
  output logic              irqN
);
  logic [REG_W-1:0] maskReg;
  logic [REG_W-1:0] modeReg;
  logic [REG_W-1:0] statusNext;

  always_comb begin
    strobes.rdEn  = rdStrobe;
    strobes.rdSel = rdSel;
    for (int p = 0; p < NUM_PHASES; p++)
      strobes.clrAcc[p] = rdStrobe & modeReg[RD_RESET_BIT] & (rdSel == SEL_W'(p));
  end

  always_comb begin
    statusNext = statusReg;
    if (wrEn && wrAddr == ADDR_STATUS) statusNext = statusReg & ~wrData;
    if (halfEvt) statusNext[HALF_FLAG] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReg <= '0;
      maskReg   <= '0;
      modeReg   <= '0;
    end else begin
      statusReg <= statusNext;
      if (wrEn && wrAddr == ADDR_MASK) maskReg <= wrData;
      if (wrEn && wrAddr == ADDR_MODE) modeReg <= wrData;
    end
  end

  assign irqN = ~|(statusReg & maskReg);
endmodule

// File: rtl/eacc_top.sv
module eacc_top
  import eacc_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sampleTick,
  input  logic [NUM_PHASES-1:0] pulseIn,
  input  logic                  rdStrobe,
  input  logic [SEL_W-1:0]      rdSel,
  output logic [ACC_W-1:0]      rdData,
  output logic                  rdValid,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [REG_W-1:0]      wrData,
  output logic [REG_W-1:0]      statusOut,
  output logic                  irqN
);
  dpStrobes_t                          strobes;
  logic                                halfEvt;
  logic [NUM_PHASES-1:0][ACC_W-1:0]    accVal;

  eacc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .rdSel(rdSel),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .halfEvt(halfEvt),
    .strobes(strobes), .statusReg(statusOut), .irqN(irqN)
  );

  eacc_datapath #(.ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .pulseIn(pulseIn),
    .strobes(strobes), .rdData(rdData), .rdValid(rdValid),
    .halfEvt(halfEvt), .accVal(accVal)
  );
endmodule

// File: rtl/eacc_checker.sv
module eacc_checker
  import eacc_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input logic                               clk,
  input logic                               rstN,
  input logic                               sampleTick,
  input logic                               rdStrobe,
  input logic                               rdValid,
  input logic                               wrEn,
  input logic [ADDR_W-1:0]                  wrAddr,
  input logic [REG_W-1:0]                   wrData,
  input logic [REG_W-1:0]                   statusOut,
  input logic                               irqN,
  input logic                               halfEvt,
  input logic [NUM_PHASES-1:0][ACC_W-1:0]   accVal
);
  // R2: with no tick and no read the counters cannot move
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleTick && !rdStrobe) |=> $stable(accVal));

  // R3: counters never go negative
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    !(accVal[0][ACC_W-1] || accVal[1][ACC_W-1] || accVal[2][ACC_W-1]));

  // R4: read response one cycle after strobe
  a_r4_read_valid: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> rdValid);
  a_r4_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> !rdValid);

  // R5: half-full flag follows the crossing event
  a_r5_event_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    halfEvt |=> statusOut[HALF_FLAG]);
  a_r5_flag_only_from_event: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[HALF_FLAG]) |-> $past(halfEvt));

  // R6: write-one clears when no event competes
  a_r6_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_STATUS && wrData[HALF_FLAG] && !halfEvt) |=> !statusOut[HALF_FLAG]);

  // R7: interrupt only asserted with a status bit pending
  a_r7_irq_needs_status: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> (statusOut != '0));
endmodule

bind eacc_top eacc_checker #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rdStrobe(rdStrobe),
  .rdValid(rdValid), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .statusOut(statusOut), .irqN(irqN), .halfEvt(halfEvt), .accVal(accVal)
);

// File: tb/sim_eacc_top.sv
module sim_eacc_top;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_W      = 8;
  localparam int SAT        = (1 << (ACC_W-1)) - 1;
  localparam int HALF_LO    = (1 << (ACC_W-2)) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b0;
  logic [2:0] pulseIn = '0;
  logic rdStrobe = 1'b0;
  logic [1:0] rdSel = '0;
  logic [ACC_W-1:0] rdData;
  logic rdValid;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] statusOut;
  logic irqN;

  int compared = 0;
  int mismatched = 0;
  int expAcc [3] = '{0, 0, 0};
  bit expHalf = 1'b0;
  logic [7:0] expMask = '0;
  logic [7:0] expMode = '0;
  int expRd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eacc_top #(.ACC_W(ACC_W)) u0 (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .pulseIn(pulseIn),
    .rdStrobe(rdStrobe), .rdSel(rdSel), .rdData(rdData), .rdValid(rdValid),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .statusOut(statusOut), .irqN(irqN)
  );

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle of stimulus plus model update; outputs sampled on the next negedge
  task automatic step(bit t, bit [2:0] p, bit rd, bit [1:0] sel,
                      bit wr, bit [1:0] addr, bit [7:0] data);
    logic [7:0] oldMode;
    bit hit;
    @(negedge clk);
    sampleTick = t; pulseIn = p; rdStrobe = rd; rdSel = sel;
    wrEn = wr; wrAddr = addr; wrData = data;
    @(negedge clk);
    sampleTick = 0; pulseIn = '0; rdStrobe = 0; wrEn = 0;
    oldMode = expMode;
    hit = 0;
    if (rd) expRd = (sel < 3) ? expAcc[sel] : 0;
    if (wr) begin
      if (addr == 2'd0 && data[4]) expHalf = 0;
      if (addr == 2'd1) expMask = data;
      if (addr == 2'd2) expMode = data;
    end
    for (int i = 0; i < 3; i++) begin
      if (rd && oldMode[6] && sel == i) expAcc[i] = (t && p[i]) ? 1 : 0;
      else if (t && p[i] && expAcc[i] < SAT) begin
        if (expAcc[i] == HALF_LO) hit = 1;
        expAcc[i]++;
      end
    end
    if (hit) expHalf = 1;
  endtask

  task automatic checkFlags(string tag);
    chk({tag, " status"}, int'(statusOut), expHalf ? 16 : 0);
    chk({tag, " irqN"}, int'(irqN), (expHalf && expMask[4]) ? 0 : 1);
  endtask

  task automatic readChk(string tag, bit [1:0] sel);
    step(0, 3'b000, 1, sel, 0, 0, 0);
    chk({tag, " rdValid"}, int'(rdValid), 1);
    chk({tag, " rdData"}, int'(rdData), expRd);
  endtask

  task automatic pulses(bit [2:0] p, int n);
    for (int k = 0; k < n; k++) step(1, p, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reset;
    chk("R1 rdValid", int'(rdValid), 0);
    chk("R1 rdData", int'(rdData), 0);
    checkFlags("R1");
    for (int s = 0; s < 3; s++) readChk("R1 counter zero", 2'(s));
  endtask

  task automatic t_accumulate;
    pulses(3'b101, 3);
    pulses(3'b010, 2);
    for (int k = 0; k < 4; k++) step(0, 3'b111, 0, 0, 0, 0, 0); // R2 no tick
    pulses(3'b111, 1);
    readChk("R2 phase A", 2'd0);
    readChk("R2 phase B", 2'd1);
    readChk("R2 phase C", 2'd2);
    readChk("R4 nondestructive reread", 2'd0);
    readChk("R4 unused select", 2'd3);
    readChk("R4 after unused select", 2'd1);
  endtask

  task automatic t_halfFull;
    pulses(3'b001, HALF_LO - expAcc[0]);
    checkFlags("R5 below half");
    pulses(3'b001, 1);
    checkFlags("R5 crossing, R7 masked");
    step(0, 0, 0, 0, 1, 2'd1, 8'h10);
    checkFlags("R7 unmasked");
    step(0, 0, 0, 0, 1, 2'd0, 8'h00);
    checkFlags("R6 write zero");
    step(0, 0, 0, 0, 1, 2'd0, 8'hEF);
    checkFlags("R6 other bits");
    step(0, 0, 0, 0, 1, 2'd0, 8'h10);
    checkFlags("R6 clear, R7 release");
  endtask

  task automatic t_saturate;
    pulses(3'b001, SAT - expAcc[0] + 5);
    readChk("R3 saturated", 2'd0);
    checkFlags("R5 no set at saturation");
  endtask

  task automatic t_readReset;
    step(0, 0, 0, 0, 1, 2'd2, 8'h40);
    readChk("R8 read value", 2'd1);
    readChk("R8 cleared", 2'd1);
    readChk("R8 saturated read", 2'd0);
    readChk("R8 saturated cleared", 2'd0);
    checkFlags("R5 clear does not set");
    step(1, 3'b100, 1, 2'd2, 0, 0, 0);
    chk("R9 read value", int'(rdData), expRd);
    readChk("R9 pulse kept", 2'd2);
    chk("R9 value is one", int'(rdData), 1);
  endtask

  task automatic t_setWins;
    step(0, 0, 0, 0, 1, 2'd2, 8'h00);
    pulses(3'b010, HALF_LO - expAcc[1]);
    step(1, 3'b010, 0, 0, 1, 2'd0, 8'h10);
    checkFlags("R6 set wins over clear");
    step(0, 0, 0, 0, 1, 2'd0, 8'h10);
    checkFlags("R6 later clear");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_accumulate();
    t_halfFull();
    t_saturate();
    t_readReset();
    t_setWins();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule